// File: doc/BRIEF.md
# Overlapped-Lookup Data Cache with Physical Tags

This block is a 4 KB direct-mapped data cache holding one 32-bit word per line (1024 lines of 4 bytes). It picks its line using only address bits that lie inside the 4 KB page offset. Those bits are identical in the virtual and the physical address, so the array read can start in the same cycle the request arrives, while a separate translation unit works out the physical frame. In the following cycle the translated frame number and its valid flag are presented on the translation port. The stored 20-bit physical tag of the selected line is compared with that frame to give hit or miss.

A request is a load or a word store. Stores follow a write-through, no-write-allocate policy. A store that hits updates the line and reports the hit, so the surrounding logic can forward the write to memory. A store that misses leaves the array untouched. A separate line-fill port installs a word and its physical tag at a given line and marks the line valid. A synchronous invalidate-all input empties the cache. The geometry parameters are checked during elaboration, so that the line index and the byte offset together never use more bits than the page offset holds.

Top module: `vipt_dcache`

## Requirements
- R1: After reset every line is invalid: a load to any line misses, and `resp_valid` is low until a request has been accepted.
- R2: The line index is `req_vaddr[11:2]`. Bits `req_vaddr[31:12]` and `req_vaddr[1:0]` do not affect which line is read or written.
- R3: A request accepted at a clock edge (`req_valid` high) gives `resp_valid` high for exactly the following cycle. `resp_hit` and `resp_rdata` in that cycle are evaluated against the `xlat_valid` and `xlat_frame` inputs of that same cycle.
- R4: `resp_hit` is high only when the line is valid, `xlat_valid` is high and the stored frame equals `xlat_frame`. On a hit `resp_rdata` is the line's word; otherwise it is zero.
- R5: A clock edge with `fill_valid` high writes `fill_data` and `fill_frame` into line `fill_index` and marks it valid, replacing any earlier contents of that line.
- R6: A store that hits writes `req_wdata` into the line at the response cycle's closing edge and keeps the tag and valid bit unchanged.
- R7: A store to an invalid line or with a mismatched frame reports a miss and leaves the line's word, tag and valid bit unchanged.
- R8: With `xlat_valid` low in the response cycle, the access reports a miss even if the frame matches, and a store does not change the line.
- R9: A clock edge with `inv_all` high invalidates every line. A fill at the same edge still leaves its own line valid.
- R10: A load accepted at the edge where a hitting store to the same line is written returns the newly stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted at the rising edge |
| req_write | input | 1 | 1 = word store, 0 = load |
| req_vaddr | input | 32 | Virtual address of the request |
| req_wdata | input | 32 | Store data |
| xlat_valid | input | 1 | Translation result valid, in the response cycle |
| xlat_frame | input | 20 | Translated physical frame number, in the response cycle |
| resp_valid | output | 1 | Response cycle of an accepted request |
| resp_hit | output | 1 | Line valid, translation valid and tags equal |
| resp_rdata | output | 32 | Line word on a hit, zero otherwise |
| fill_valid | input | 1 | Line-fill strobe |
| fill_index | input | 10 | Line to fill |
| fill_frame | input | 20 | Physical tag to install |
| fill_data | input | 32 | Word to install |
| inv_all | input | 1 | Invalidate every line at this edge |

## Verification
The assertions assume that `req_valid` is driven low during reset. They also assume that a fill or invalidate to the line of a request still in its response cycle does not occur, because the hit there is judged on the line state sampled one edge earlier. The stimulus never overlaps fills or invalidates with an outstanding request, except in the single deliberate case of invalidate-with-fill. Translation inputs are held stable from the response cycle's start through its closing edge. Back-to-back requests are limited to the store-then-load pairs that exercise forwarding.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  localparam int VA_W_DEF        = 32;
  localparam int PAGE_OFF_W_DEF  = 12;
  localparam int CACHE_BYTES_DEF = 4096;
  localparam int LINE_BYTES_DEF  = 4;

  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } op_e;
endpackage

// File: rtl/vipt_array.sv
// Word-per-line storage with two write ports (port b wins on the same line)
// and a registered read that forwards same-edge writes.
module vipt_array #(
  parameter int W     = 32,
  parameter int IDX_W = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             a_we,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [W-1:0]     a_data,
  input  logic             b_we,
  input  logic [IDX_W-1:0] b_idx,
  input  logic [W-1:0]     b_data,
  output logic [W-1:0]     rd_data
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rd_d;
  logic [W-1:0] rd_q;

  always_comb begin
    if (b_we && (b_idx == rd_idx))      rd_d = b_data;
    else if (a_we && (a_idx == rd_idx)) rd_d = a_data;
    else                                rd_d = mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (a_we) mem[a_idx] <= a_data;
    if (b_we) mem[b_idx] <= b_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= rd_d;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/vipt_valid_bits.sv
// Per-line valid flags with bulk clear, single set port and forwarded read.
module vipt_valid_bits #(
  parameter int IDX_W = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             set_we,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid
);
  logic [DEPTH-1:0] valid_q, valid_d;
  logic             rd_q, rd_d;

  always_comb begin
    valid_d = clr_all ? '0 : valid_q;
    if (set_we) valid_d[set_idx] = 1'b1;
    if (set_we && (set_idx == rd_idx)) rd_d = 1'b1;
    else if (clr_all)                  rd_d = 1'b0;
    else                               rd_d = valid_q[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rd_q    <= 1'b0;
    end else begin
      if (set_we || clr_all) valid_q <= valid_d;
      if (rd_en)             rd_q    <= rd_d;
    end
  end

  assign rd_valid = rd_q;
endmodule

// File: rtl/vipt_hit_cmp.sv
// Physical tag comparison against the translated frame.
module vipt_hit_cmp #(
  parameter int FRAME_W = 20
) (
  input  logic               line_valid,
  input  logic [FRAME_W-1:0] line_tag,
  input  logic               xlat_valid,
  input  logic [FRAME_W-1:0] xlat_frame,
  output logic               hit
);
  assign hit = line_valid && xlat_valid && (line_tag == xlat_frame);
endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache
  import vipt_pkg::*;
#(
  parameter int VA_W        = VA_W_DEF,
  parameter int PAGE_OFF_W  = PAGE_OFF_W_DEF,
  parameter int CACHE_BYTES = CACHE_BYTES_DEF,
  parameter int LINE_BYTES  = LINE_BYTES_DEF,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int IDX_W   = $clog2(CACHE_BYTES / LINE_BYTES),
  localparam int FRAME_W = VA_W - PAGE_OFF_W,
  localparam int DATA_W  = 8 * LINE_BYTES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               xlat_valid,
  input  logic [FRAME_W-1:0] xlat_frame,
  output logic               resp_valid,
  output logic               resp_hit,
  output logic [DATA_W-1:0]  resp_rdata,
  input  logic               fill_valid,
  input  logic [IDX_W-1:0]   fill_index,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic [DATA_W-1:0]  fill_data,
  input  logic               inv_all
);
  // The index must come from untranslated bits only.
  if (IDX_W + OFF_W > PAGE_OFF_W) begin : g_geom_bad
    $error("line index and byte offset exceed the page offset");
  end

  logic [IDX_W-1:0]   req_idx;
  logic               unused_va;
  logic               s1_valid_q, s1_valid_d;
  op_e                s1_op_q, s1_op_d;
  logic [IDX_W-1:0]   s1_idx_q, s1_idx_d;
  logic [DATA_W-1:0]  s1_wdata_q, s1_wdata_d;
  logic               line_valid;
  logic [FRAME_W-1:0] line_tag;
  logic [DATA_W-1:0]  line_data;
  logic               hit;
  logic               store_we;

  assign req_idx   = req_vaddr[OFF_W +: IDX_W];
  assign unused_va = ^{req_vaddr[VA_W-1:OFF_W+IDX_W], req_vaddr[OFF_W-1:0]};

  // Stage-1 next state
  always_comb begin
    s1_valid_d = req_valid;
    s1_op_d    = s1_op_q;
    s1_idx_d   = s1_idx_q;
    s1_wdata_d = s1_wdata_q;
    if (req_valid) begin
      s1_op_d    = req_write ? OP_STORE : OP_LOAD;
      s1_idx_d   = req_idx;
      s1_wdata_d = req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_op_q    <= OP_LOAD;
      s1_idx_q   <= '0;
      s1_wdata_q <= '0;
    end else begin
      s1_valid_q <= s1_valid_d;
      if (req_valid) begin
        s1_op_q    <= s1_op_d;
        s1_idx_q   <= s1_idx_d;
        s1_wdata_q <= s1_wdata_d;
      end
    end
  end

  vipt_valid_bits #(.IDX_W(IDX_W)) u_valid (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (inv_all),
    .set_we   (fill_valid),
    .set_idx  (fill_index),
    .rd_en    (req_valid),
    .rd_idx   (req_idx),
    .rd_valid (line_valid)
  );

  vipt_array #(.W(FRAME_W), .IDX_W(IDX_W)) u_tags (
    .clk     (clk),
    .rd_en   (req_valid),
    .rd_idx  (req_idx),
    .a_we    (1'b0),
    .a_idx   ('0),
    .a_data  ('0),
    .b_we    (fill_valid),
    .b_idx   (fill_index),
    .b_data  (fill_frame),
    .rd_data (line_tag)
  );

  vipt_array #(.W(DATA_W), .IDX_W(IDX_W)) u_data (
    .clk     (clk),
    .rd_en   (req_valid),
    .rd_idx  (req_idx),
    .a_we    (store_we),
    .a_idx   (s1_idx_q),
    .a_data  (s1_wdata_q),
    .b_we    (fill_valid),
    .b_idx   (fill_index),
    .b_data  (fill_data),
    .rd_data (line_data)
  );

  vipt_hit_cmp #(.FRAME_W(FRAME_W)) u_cmp (
    .line_valid (line_valid),
    .line_tag   (line_tag),
    .xlat_valid (xlat_valid),
    .xlat_frame (xlat_frame),
    .hit        (hit)
  );

  assign store_we   = s1_valid_q && (s1_op_q == OP_STORE) && hit;
  assign resp_valid = s1_valid_q;
  assign resp_hit   = s1_valid_q && hit;
  assign resp_rdata = resp_hit ? line_data : '0;
endmodule

// File: rtl/vipt_dcache_chk.sv
module vipt_dcache_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              xlat_valid,
  input logic              fill_valid,
  input logic              inv_all,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic [DATA_W-1:0] resp_rdata
);
  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid); // R3
  AST_NO_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid); // R3
  AST_HIT_IN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    resp_hit |-> resp_valid); // R3
  AST_HIT_NEEDS_XLAT: assert property (@(posedge clk) disable iff (!rst_n)
    resp_hit |-> xlat_valid); // R8
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> (resp_rdata == '0)); // R4
  AST_INV_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && inv_all && !fill_valid) |=> !resp_hit); // R9
endmodule

bind vipt_dcache vipt_dcache_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .xlat_valid (xlat_valid),
  .fill_valid (fill_valid),
  .inv_all    (inv_all),
  .resp_valid (resp_valid),
  .resp_hit   (resp_hit),
  .resp_rdata (resp_rdata)
);

// File: tb/tb_vipt_dcache.sv
`timescale 1ns/100ps
module tb_vipt_dcache;
  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_vaddr, req_wdata;
  logic        xlat_valid;
  logic [19:0] xlat_frame;
  logic        resp_valid, resp_hit;
  logic [31:0] resp_rdata;
  logic        fill_valid;
  logic [9:0]  fill_index;
  logic [19:0] fill_frame;
  logic [31:0] fill_data;
  logic        inv_all;

  int checks = 0, errors = 0;
  bit done = 0;

  logic        m_v [1024];
  logic [19:0] m_t [1024];
  logic [31:0] m_d [1024];

  vipt_dcache dut (.*);

  initial clk = 0;
  always #2 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic [19:0] fr_of(input int i);
    return 20'((i * 37 + 5) ^ 20'h3C000);
  endfunction
  function automatic [31:0] dat_of(input int i);
    return 32'(i) * 32'h9E3779B1 ^ 32'h5A5A0000;
  endfunction
  function automatic [31:0] va_of(input int i, input int salt);
    return {20'(i ^ (salt * 20'h1357)), 10'(i), 2'(salt)};
  endfunction

  task automatic do_fill(input int i, input logic [19:0] fr, input logic [31:0] d, input logic inv);
    @(negedge clk);
    fill_valid = 1; fill_index = 10'(i); fill_frame = fr; fill_data = d; inv_all = inv;
    @(negedge clk);
    fill_valid = 0; inv_all = 0;
    if (inv) for (int k = 0; k < 1024; k++) m_v[k] = 0;
    m_v[i] = 1; m_t[i] = fr; m_d[i] = d;
  endtask

  // One isolated access; checks response against the model and updates it.
  task automatic access(input string req, input logic wr, input int i, input int salt,
                        input logic [31:0] wd, input logic xv, input logic [19:0] fr);
    logic eh;
    logic [31:0] ed;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_vaddr = va_of(i, salt); req_wdata = wd;
    @(posedge clk); #0.5;
    req_valid = 0; xlat_valid = xv; xlat_frame = fr;
    #0.5;
    eh = xv && m_v[i] && (m_t[i] == fr);
    ed = eh ? m_d[i] : 32'h0;
    chk(resp_valid === 1'b1, {req, " resp_valid"}, {31'h0, resp_valid}, 32'h1);
    chk(resp_hit === eh, {req, " hit"}, {31'h0, resp_hit}, {31'h0, eh});
    chk(resp_rdata === ed, {req, " data"}, resp_rdata, ed);
    @(posedge clk); #0.5;
    xlat_valid = 0;
    if (wr && eh) m_d[i] = wd;
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_vaddr = 0; req_wdata = 0;
    xlat_valid = 0; xlat_frame = 0; fill_valid = 0; fill_index = 0;
    fill_frame = 0; fill_data = 0; inv_all = 0;
    for (int k = 0; k < 1024; k++) begin m_v[k] = 0; m_t[k] = 0; m_d[k] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(resp_valid === 1'b0, "R1 idle resp_valid", {31'h0, resp_valid}, 32'h0);
    access("R1 load after reset", 0, 0, 1, 0, 1, fr_of(0));
    access("R1 load after reset", 0, 1023, 2, 0, 1, 20'h0);
    access("R1 load after reset", 0, 512, 3, 0, 1, fr_of(512));

    // R5: fill every line
    for (int i = 0; i < 1024; i++) do_fill(i, fr_of(i), dat_of(i), 0);
    // R2, R3, R4: load every line with varying upper and byte-offset bits
    for (int i = 0; i < 1024; i++) access("R2 R4 sweep hit", 0, i, i % 4, 0, 1, fr_of(i));
    // R4: tag mismatch
    for (int i = 0; i < 1024; i += 8) access("R4 frame mismatch", 0, i, 1, 0, 1, fr_of(i) ^ 20'h1);
    // R8: translation not valid
    for (int i = 3; i < 1024; i += 64) access("R8 xlat invalid load", 0, i, 2, 0, 0, fr_of(i));
    for (int i = 5; i < 1024; i += 64) begin
      access("R8 xlat invalid store", 1, i, 0, 32'hDEAD0000 + 32'(i), 0, fr_of(i));
      access("R8 readback", 0, i, 3, 0, 1, fr_of(i));
    end
    // R6: store hits then readback
    for (int i = 0; i < 1024; i += 4) access("R6 store hit", 1, i, 2, ~dat_of(i), 1, fr_of(i));
    for (int i = 0; i < 1024; i += 4) access("R6 readback", 0, i, 1, 0, 1, fr_of(i));
    // R7: store with wrong frame leaves line unchanged
    for (int i = 2; i < 1024; i += 16) begin
      access("R7 store miss", 1, i, 0, 32'hBADC0DE0, 1, fr_of(i) ^ 20'h80000);
      access("R7 readback", 0, i, 2, 0, 1, fr_of(i));
    end
    // R5: refill overwrites tag and data
    do_fill(100, 20'hABCDE, 32'h12345678, 0);
    access("R5 old tag", 0, 100, 0, 0, 1, fr_of(100));
    access("R5 new tag", 0, 100, 1, 0, 1, 20'hABCDE);

    // R10: store hit followed at once by a load to the same line
    for (int t = 0; t < 8; t++) begin
      int i;
      logic [31:0] wd;
      i = t * 97 + 11;
      wd = 32'hC0FFEE00 + 32'(t);
      @(negedge clk);
      req_valid = 1; req_write = 1; req_vaddr = va_of(i, 1); req_wdata = wd;
      @(posedge clk); #0.5;
      xlat_valid = 1; xlat_frame = m_t[i];
      req_write = 0; req_vaddr = va_of(i, 3);
      #0.5;
      chk(resp_hit === 1'b1, "R10 store hit", {31'h0, resp_hit}, 32'h1);
      @(posedge clk); #0.5;
      req_valid = 0;
      #0.5;
      chk(resp_hit === 1'b1, "R10 load hit", {31'h0, resp_hit}, 32'h1);
      chk(resp_rdata === wd, "R10 forwarded data", resp_rdata, wd);
      @(posedge clk); #0.5;
      xlat_valid = 0;
      m_d[i] = wd;
    end

    // R9: invalidate all with a fill to line 5 at the same edge
    do_fill(5, 20'h55555, 32'h0BADF00D, 1);
    access("R9 filled line stays", 0, 5, 2, 0, 1, 20'h55555);
    for (int i = 0; i < 1024; i += 37) access("R9 invalidated", 0, i, 1, 0, 1, fr_of(i));
    access("R9 store after inv", 1, 6, 0, 32'h1, 1, fr_of(6));
    do_fill(6, fr_of(6), 32'h66, 0);
    access("R9 refill", 0, 6, 1, 0, 1, fr_of(6));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule